// File: doc/BRIEF.md
# Pushbutton Combination Lock Controller

This block is the clocked controller of a mechanical-style door lock with four numbered pushbuttons and a turn knob. A user keys in a combination made of several button groups. Within a group the member buttons may be pressed in any order, together or one after another, because the system clock runs far faster than a hand can move. The controller therefore remembers every press until the group is complete. Releasing all buttons closes a group and opens the next one. A digit may appear in more than one group.

Turning the knob submits the entry. If every group was entered correctly and nothing stray was pressed, the unlock output goes high for as long as the knob stays turned. When the knob returns, the whole entry is cleared, whether it was right or wrong. The default combination is {1,2}, then {3,4}, then {2}. It is a parameter packed one group per nibble, with group 0 in the low nibble and button 1 in bit 0 of each nibble.

Top module: `pushlock`

## Requirements
- R1: While `rst` is high the lock is idle: `unlock` is 0, and any partly entered combination is discarded. The reset acts at once, without waiting for a clock edge.
- R2: The button inputs are active-low. Bit i of `key_n` at 0 means button i+1 is held, so bit 0 is button 1 and bit 3 is button 4.
- R3: Three groups entered in order, {1,2} then {3,4} then {2}, followed by raising `knob`, make `unlock` 1 at the first clock edge that samples `knob` high. Reuse of button 2 in two groups is allowed.
- R4: Within a group the order of presses does not matter. Presses may be simultaneous or separated by releases. Holding a button for many cycles counts as one press.
- R5: A group completes only when all of its buttons have been seen pressed and then every button is released. A release after only part of the group keeps the presses already made.
- R6: Pressing a button outside the current group's set puts the lock in error. Later presses are ignored, and `unlock` stays 0 on the next knob turn.
- R7: `unlock` is 1 only while `knob` is sampled high after a complete, error-free entry. It returns to 0 at the first clock edge that samples `knob` low.
- R8: Raising `knob` before the third group is complete leaves `unlock` at 0.
- R9: After `knob` falls, the entry is cleared, and a following knob turn with no new entry gives 0. A full correct entry then unlocks again.
- R10: Any button press after the third group is complete, before the knob is turned, counts as an error.
- R11: Button activity while `knob` is high changes nothing: a held unlock stays at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Asynchronous reset, active-high |
| key_n | input | KEYS | Number buttons, active-low, bit 0 = button 1 |
| knob | input | 1 | Knob turned when 1 |
| unlock | output | 1 | Door may open when 1 |

## Verification
Every single-shot press pattern is tried in the first and in the last group, and every ordered pair of buttons is tried in the middle group. A design that compared groups by order rather than by set, or that accepted a subset or a superset, would unlock on the wrong patterns. Partial releases and the digit shared between groups expose a design that forgets presses too early or keeps them too long. Further cases cover a stray press after completion, buttons pressed while the knob is held, and a knob turn on an empty entry after a success; these catch a sticky unlock or an error flag that is never cleared. An asynchronous reset in mid-entry checks that progress is really discarded.

// File: rtl/pushlock.sv
module pushlock #(
  parameter int KEYS = 4,
  parameter int GROUPS = 3,
  parameter logic [KEYS*GROUPS-1:0] CODE = 12'h2C3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [KEYS-1:0] key_n,
  input  logic            knob,
  output logic            unlock
);
  localparam int SW = $clog2(GROUPS + 1);

  logic [KEYS-1:0] btn, seen, want;
  logic [SW-1:0]   stage;
  logic            err, knob_q, done, stray, idle_keys;

  assign btn       = ~key_n;
  assign done      = (stage == SW'(GROUPS));
  assign stray     = |(btn & ~want);
  assign idle_keys = (btn == '0);

  always_comb begin
    want = '0;
    for (int g = 0; g < GROUPS; g++)
      if (stage == SW'(g)) want = CODE[g*KEYS +: KEYS];
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      stage  <= '0;
      seen   <= '0;
      err    <= 1'b0;
      knob_q <= 1'b0;
      unlock <= 1'b0;
    end else begin
      knob_q <= knob;
      unlock <= knob & done & ~err;
      if (knob_q && !knob) begin
        stage <= '0;
        seen  <= '0;
        err   <= 1'b0;
      end else if (!knob && !err) begin
        if (stray) begin
          err <= 1'b1;
        end else if (idle_keys) begin
          if (!done && seen == want) begin
            stage <= stage + 1'b1;
            seen  <= '0;
          end
        end else begin
          seen <= seen | btn;
        end
      end
    end
  end
endmodule

// File: rtl/pushlock_chk.sv
module pushlock_chk #(
  parameter int KEYS = 4,
  parameter int GROUPS = 3,
  parameter int SW = 2
) (
  input logic            clk,
  input logic            rst,
  input logic [KEYS-1:0] key_n,
  input logic            knob,
  input logic            unlock,
  input logic [SW-1:0]   stage,
  input logic            err,
  input logic            knob_q
);
  AST_STAGE_RANGE: assert property (@(posedge clk) disable iff (rst)
    stage <= SW'(GROUPS)); // R3
  AST_UNLOCK_NEEDS_KNOB: assert property (@(posedge clk) disable iff (rst)
    unlock |-> $past(knob)); // R7
  AST_UNLOCK_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
    unlock |-> (stage == SW'(GROUPS))); // R8
  AST_UNLOCK_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    unlock |-> !err); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err && !knob && !knob_q) |=> err); // R6
  AST_KNOB_FALL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (knob_q && !knob) |=> (stage == '0 && !err)); // R9
  AST_ADVANCE_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (stage != $past(stage) && stage != '0) |-> ($past(&key_n) && stage == $past(stage) + SW'(1))); // R5
  AST_KNOB_FREEZES: assert property (@(posedge clk) disable iff (rst)
    (knob && knob_q) |=> $stable(stage)); // R11
endmodule

bind pushlock pushlock_chk #(.KEYS(KEYS), .GROUPS(GROUPS), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .key_n(key_n), .knob(knob), .unlock(unlock),
  .stage(stage), .err(err), .knob_q(knob_q)
);

// File: tb/pushlock_bench.sv
module pushlock_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] key_n = 4'hF;
  logic       knob = 1'b0;
  logic       unlock;
  int total = 0, bad = 0, cycles = 0;

  pushlock u_pushlock (.clk(clk), .rst(rst), .key_n(key_n), .knob(knob), .unlock(unlock));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog: cycles=%0d expected under 150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R2: bit i low means button i+1 held
  task automatic grp(input logic [3:0] m);
    key_n = ~m; tick(3);
    key_n = 4'hF; tick(2);
  endtask

  task automatic good_code();
    grp(4'b0011); grp(4'b1100); grp(4'b0010);
  endtask

  task automatic turn(input bit exp, input string req);
    knob = 1'b1; tick(1);
    chk(unlock == exp, req, unlock, exp);
    tick(2);
    chk(unlock == exp, req, unlock, exp);
    knob = 1'b0; tick(1);
    chk(unlock == 1'b0, "R7", unlock, 0);
    tick(1);
  endtask

  initial begin
    tick(2);
    chk(unlock == 1'b0, "R1", unlock, 0);
    rst = 1'b0; tick(2);

    good_code(); turn(1'b1, "R3");
    turn(1'b0, "R9");
    good_code(); turn(1'b1, "R9");

    for (int m = 0; m < 16; m++) begin
      grp(4'(m)); grp(4'b1100); grp(4'b0010);
      turn(m == 3, "R3");
    end
    for (int m = 0; m < 16; m++) begin
      grp(4'b0011); grp(4'b1100); grp(4'(m));
      turn(m == 2, "R10");
    end
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        grp(4'b0011);
        grp(4'(1 << i)); grp(4'(1 << j));
        grp(4'b0010);
        turn(((4'(1 << i)) | (4'(1 << j))) == 4'b1100, "R4");
      end

    key_n = 4'b1101; tick(2); key_n = 4'b1100; tick(40); key_n = 4'b1110; tick(3);
    key_n = 4'hF; tick(2);
    grp(4'b1000); grp(4'b0100); grp(4'b0010);
    turn(1'b1, "R4");

    grp(4'b0001); grp(4'b0100);
    grp(4'b1100); grp(4'b0010);
    turn(1'b0, "R5");

    grp(4'b0011); grp(4'b1100); grp(4'b0010); grp(4'b0010);
    turn(1'b0, "R10");

    grp(4'b0101); good_code();
    turn(1'b0, "R6");
    good_code(); turn(1'b1, "R6");

    turn(1'b0, "R8");
    grp(4'b0011); turn(1'b0, "R8");
    grp(4'b0011); grp(4'b1100); turn(1'b0, "R8");

    good_code();
    knob = 1'b1; tick(2);
    key_n = 4'b1011; tick(3); key_n = 4'hF; tick(2);
    chk(unlock == 1'b1, "R11", unlock, 1);
    knob = 1'b0; tick(2);
    chk(unlock == 1'b0, "R7", unlock, 0);

    grp(4'b0011); grp(4'b1100);
    #3 rst = 1'b1; #2;
    chk(unlock == 1'b0, "R1", unlock, 0);
    tick(1); rst = 1'b0; tick(1);
    grp(4'b0010); turn(1'b0, "R1");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule